// File: doc/BRIEF.md
# Fixed-Vector Restart Interrupt Controller

This block arbitrates five interrupt sources for a small 8-bit processor core. One trap input cannot be masked. Three restart inputs (ranked 7.5, 6.5 and 5.5) each lead to a hard-wired 16-bit service address. A general request line takes its instruction from the external 8-bit data bus instead of from a fixed address. The block holds a 3-bit mask register for the restart inputs and a global enable flag. The core raises a boundary strobe at each instruction boundary. The controller decides only on those cycles.

When a restart source or the trap wins, the controller pulses a service request and a push-PC command, and presents the source's vector. When the general request wins, it pulses the service request with a one-cycle acknowledge. It registers the byte on the data bus during that acknowledge cycle and hands the byte to the core on the following cycle, qualified by a valid pulse. The core's stack and decoder act on these signals. They are outside this block.

Top module: `vecirq_ctrl`

## Requirements
- R1: After reset no pending latch is set, the enable flag is clear and all three mask bits are set, so a maskable source is not serviced until the core unmasks it and strobes enable. All outputs are low after reset.
- R2: The trap bypasses both the mask and the enable flag. When it is accepted, svc_req_o and push_pc_o pulse one cycle after the accepting boundary, and vector_o reads 0x0024.
- R3: When a restart source is accepted, svc_req_o and push_pc_o pulse with vector_o set to 0x003C for 7.5, 0x0034 for 6.5 and 0x002C for 5.5.
- R4: The priority order, from highest to lowest, is trap, 7.5, 6.5, 5.5, then the general request. Exactly one source is granted per accepting boundary.
- R5: Any acceptance clears the enable flag, and only the ei_i strobe sets it again. When acceptance and ei_i occur in the same cycle, the clear takes precedence.
- R6: Mask bits come from mask_data_i on mask_wr_i: bit 0 covers 5.5, bit 1 covers 6.5 and bit 2 covers 7.5, and a 1 blocks the source. A 7.5 edge that arrives while masked stays latched and is serviced once the bit is cleared.
- R7: The clr75_i strobe clears a latched 7.5 edge. If a new edge arrives in the same cycle, the new edge is kept.
- R8: The 6.5, 5.5 and general inputs are levels. They are sampled only on cycles with boundary_i high, and nothing is accepted on a cycle with boundary_i low.
- R9: An accepted general request gives one cycle of inta_o together with svc_req_o and no push. The data_bus_i value in that cycle appears on opcode_o one cycle later, with opcode_vld_o high for one cycle.
- R10: The trap and 7.5 inputs are captured on rising edges into pending latches that clear when serviced. A level held high after servicing does not cause a second service.
- R11: No source is accepted during the acknowledge cycle, even if boundary_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_i | input | 1 | Non-maskable trap, rising-edge captured |
| r75_i | input | 1 | Restart 7.5, rising-edge captured |
| r65_i | input | 1 | Restart 6.5, level |
| r55_i | input | 1 | Restart 5.5, level |
| gen_req_i | input | 1 | General request, level |
| boundary_i | input | 1 | Instruction-boundary strobe from the core |
| mask_wr_i | input | 1 | Load strobe for the mask register |
| mask_data_i | input | 3 | New mask value: bit 0 covers 5.5, bit 1 covers 6.5, bit 2 covers 7.5 |
| ei_i | input | 1 | Strobe that sets the enable flag |
| clr75_i | input | 1 | Strobe that clears the 7.5 pending latch |
| data_bus_i | input | 8 | External data bus |
| svc_req_o | output | 1 | Service request pulse to the core |
| push_pc_o | output | 1 | Command to push the program counter |
| vector_o | output | 16 | Service address, valid with push_pc_o |
| inta_o | output | 1 | Acknowledge cycle for the general request |
| opcode_o | output | 8 | Fetched instruction byte |
| opcode_vld_o | output | 1 | opcode_o is valid |

## Verification
The assertions check the following on every cycle:
- at most one grant per cycle, and only on a boundary that is not blocked;
- a push always carries one of the four legal vectors;
- the enable flag drops after every acceptance;
- the acknowledge lasts one cycle, is never paired with a push and is always followed by a valid opcode.

Priority between simultaneous sources, the survival of a masked 7.5 edge, clearing by the strobe, no retrigger on held levels and lockout during the acknowledge depend on sequences of stimulus. The bench's directed scenarios and its random run, compared against a cycle model, are what show these.

// File: rtl/vecirq_pkg.sv
package vecirq_pkg;
  localparam int VEC_W  = 16;
  localparam int NSRC   = 5;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_R75  = 3'd2,
    SRC_R65  = 3'd3,
    SRC_R55  = 3'd4,
    SRC_GEN  = 3'd5
  } src_e;

  localparam logic [VEC_W-1:0] VEC_TRAP = 16'h0024;
  localparam logic [VEC_W-1:0] VEC_R55  = 16'h002C;
  localparam logic [VEC_W-1:0] VEC_R65  = 16'h0034;
  localparam logic [VEC_W-1:0] VEC_R75  = 16'h003C;

  function automatic logic [VEC_W-1:0] vec_of(input src_e s);
    case (s)
      SRC_TRAP: return VEC_TRAP;
      SRC_R75:  return VEC_R75;
      SRC_R65:  return VEC_R65;
      SRC_R55:  return VEC_R55;
      default:  return '0;
    endcase
  endfunction

  function automatic logic is_restart(input src_e s);
    return (s == SRC_TRAP) || (s == SRC_R75) || (s == SRC_R65) || (s == SRC_R55);
  endfunction
endpackage

// File: rtl/vecirq_edge_pend.sv
module vecirq_edge_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, pend_q, pend_d, rise;

  assign rise = sig_i & ~prev_q;

  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d = 1'b0;
    if (rise)  pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sig_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R10: a rising edge is always held pending on the next cycle
  assert_edge_latched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_i && !prev_q) |=> pend_o);
endmodule

// File: rtl/vecirq_arb.sv
module vecirq_arb
  import vecirq_pkg::*;
#(
  parameter int MASK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              pend_trap_i,
  input  logic              pend_r75_i,
  input  logic              lvl_r65_i,
  input  logic              lvl_r55_i,
  input  logic              lvl_gen_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              ie_i,
  output src_e              win_o
);
  logic [NSRC-1:0] req, grant;

  // index 0 is highest priority
  always_comb begin
    req[0] = pend_trap_i;
    req[1] = pend_r75_i & ~mask_i[2] & ie_i;
    req[2] = lvl_r65_i  & ~mask_i[1] & ie_i;
    req[3] = lvl_r55_i  & ~mask_i[0] & ie_i;
    req[4] = lvl_gen_i  & ie_i;
  end

  always_comb begin
    grant = '0;
    if (sample_i) begin
      for (int i = NSRC - 1; i >= 0; i--) begin
        if (req[i]) grant = NSRC'(1) << i;
      end
    end
  end

  always_comb begin
    unique case (1'b1)
      grant[0]: win_o = SRC_TRAP;
      grant[1]: win_o = SRC_R75;
      grant[2]: win_o = SRC_R65;
      grant[3]: win_o = SRC_R55;
      grant[4]: win_o = SRC_GEN;
      default:  win_o = SRC_NONE;
    endcase
  end

  assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_o != SRC_NONE) |-> sample_i);
  assert_trap_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && pend_trap_i) |-> (win_o == SRC_TRAP));
endmodule

// File: rtl/vecirq_seq.sv
module vecirq_seq
  import vecirq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  src_e              win_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              svc_req_o,
  output logic              push_pc_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic              inta_o,
  output logic [DATA_W-1:0] opcode_o,
  output logic              opcode_vld_o
);
  logic              svc_d, push_d, inta_d, ovld_d;
  logic [VEC_W-1:0]  vec_d;
  logic [DATA_W-1:0] opc_d;

  always_comb begin
    svc_d  = (win_i != SRC_NONE);
    push_d = is_restart(win_i);
    inta_d = (win_i == SRC_GEN);
    vec_d  = push_d ? vec_of(win_i) : vector_o;
    ovld_d = inta_o;
    opc_d  = inta_o ? data_i : opcode_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_req_o    <= 1'b0;
      push_pc_o    <= 1'b0;
      vector_o     <= '0;
      inta_o       <= 1'b0;
      opcode_o     <= '0;
      opcode_vld_o <= 1'b0;
    end else begin
      svc_req_o    <= svc_d;
      push_pc_o    <= push_d;
      vector_o     <= vec_d;
      inta_o       <= inta_d;
      opcode_o     <= opc_d;
      opcode_vld_o <= ovld_d;
    end
  end

  assert_push_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_pc_o |-> (vector_o == VEC_TRAP || vector_o == VEC_R75 ||
                   vector_o == VEC_R65  || vector_o == VEC_R55));
  assert_inta_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inta_o |=> !inta_o);
  assert_inta_no_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(inta_o && push_pc_o));
  assert_opcode_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inta_o |=> opcode_vld_o);
endmodule

// File: rtl/vecirq_ctrl.sv
module vecirq_ctrl
  import vecirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MASK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_i,
  input  logic              r75_i,
  input  logic              r65_i,
  input  logic              r55_i,
  input  logic              gen_req_i,
  input  logic              boundary_i,
  input  logic              mask_wr_i,
  input  logic [MASK_W-1:0] mask_data_i,
  input  logic              ei_i,
  input  logic              clr75_i,
  input  logic [DATA_W-1:0] data_bus_i,
  output logic              svc_req_o,
  output logic              push_pc_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic              inta_o,
  output logic [DATA_W-1:0] opcode_o,
  output logic              opcode_vld_o
);
  logic              ie_q, ie_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              pend_trap, pend_r75, sample, accept;
  src_e              win;

  assign sample = boundary_i & ~inta_o;
  assign accept = (win != SRC_NONE);

  always_comb begin
    ie_d = ie_q;
    if (ei_i)   ie_d = 1'b1;
    if (accept) ie_d = 1'b0;
    mask_d = mask_wr_i ? mask_data_i : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      mask_q <= '1;
    end else begin
      ie_q   <= ie_d;
      mask_q <= mask_d;
    end
  end

  vecirq_edge_pend u_trap (
    .clk(clk), .rst_n(rst_n), .sig_i(trap_i),
    .clr_i(win == SRC_TRAP), .pend_o(pend_trap)
  );

  vecirq_edge_pend u_r75 (
    .clk(clk), .rst_n(rst_n), .sig_i(r75_i),
    .clr_i((win == SRC_R75) | clr75_i), .pend_o(pend_r75)
  );

  vecirq_arb #(.MASK_W(MASK_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .sample_i(sample),
    .pend_trap_i(pend_trap), .pend_r75_i(pend_r75),
    .lvl_r65_i(r65_i), .lvl_r55_i(r55_i), .lvl_gen_i(gen_req_i),
    .mask_i(mask_q), .ie_i(ie_q), .win_o(win)
  );

  vecirq_seq #(.DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .win_i(win), .data_i(data_bus_i),
    .svc_req_o(svc_req_o), .push_pc_o(push_pc_o), .vector_o(vector_o),
    .inta_o(inta_o), .opcode_o(opcode_o), .opcode_vld_o(opcode_vld_o)
  );

  assert_ie_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ie_q);
  assert_locked_in_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inta_o |=> !svc_req_o);
endmodule

// File: tb/sim_vecirq_ctrl.sv
`timescale 1ns/1ps
module sim_vecirq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic trap, r75, r65, r55, gen, bnd, mwr, ei, clr;
  logic [2:0]  mdat;
  logic [7:0]  dbus;
  logic        svc, push, inta, ovld;
  logic [15:0] vec;
  logic [7:0]  opc;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vecirq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .trap_i(trap), .r75_i(r75), .r65_i(r65),
    .r55_i(r55), .gen_req_i(gen), .boundary_i(bnd), .mask_wr_i(mwr),
    .mask_data_i(mdat), .ei_i(ei), .clr75_i(clr), .data_bus_i(dbus),
    .svc_req_o(svc), .push_pc_o(push), .vector_o(vec), .inta_o(inta),
    .opcode_o(opc), .opcode_vld_o(ovld)
  );

  // cycle model built from the requirements
  logic m_pt, m_p75, m_ie, m_fetch, m_ptv, m_p75v;
  logic [2:0]  m_mask;
  logic        e_svc, e_push, e_inta, e_ovld;
  logic [15:0] e_vec;
  logic [7:0]  e_opc;

  function automatic int pick(logic pt, logic p75, logic ie, logic [2:0] mk,
                              logic l65, logic l55, logic lg, logic smp);
    if (!smp) return 0;
    if (pt) return 1;
    if (p75 && !mk[2] && ie) return 2;
    if (l65 && !mk[1] && ie) return 3;
    if (l55 && !mk[0] && ie) return 4;
    if (lg && ie) return 5;
    return 0;
  endfunction

  function automatic logic [15:0] vec_for(int w);
    case (w)
      1: return 16'h0024; 2: return 16'h003C;
      3: return 16'h0034; 4: return 16'h002C;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    int w;
    w = pick(m_pt, m_p75, m_ie, m_mask, r65, r55, gen, bnd && !m_fetch);
    e_svc  = (w != 0);
    e_push = (w >= 1 && w <= 4);
    e_inta = (w == 5);
    if (e_push) e_vec = vec_for(w);
    e_ovld = m_fetch;
    if (m_fetch) e_opc = dbus;
    m_pt  = (trap && !m_ptv) || (m_pt && w != 1);
    m_p75 = (r75 && !m_p75v) || (m_p75 && w != 2 && !clr);
    if (ei) m_ie = 1'b1;
    if (w != 0) m_ie = 1'b0;
    if (mwr) m_mask = mdat;
    m_fetch = e_inta;
    m_ptv = trap; m_p75v = r75;
    @(posedge clk); @(negedge clk);
    chk(tag, "svc_req", 16'(svc), 16'(e_svc));
    chk(tag, "push_pc", 16'(push), 16'(e_push));
    chk(tag, "inta", 16'(inta), 16'(e_inta));
    chk(tag, "opcode_vld", 16'(ovld), 16'(e_ovld));
    if (e_push) chk(tag, "vector", vec, e_vec);
    if (e_ovld) chk(tag, "opcode", 16'(opc), 16'(e_opc));
  endtask

  task automatic quiet();
    bnd = 0; mwr = 0; ei = 0; clr = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    trap = 0; r75 = 0; r65 = 0; r55 = 0; gen = 0; dbus = 0; mdat = 0;
    quiet();
    m_pt = 0; m_p75 = 0; m_ie = 0; m_fetch = 0; m_ptv = 0; m_p75v = 0;
    m_mask = 3'b111; e_vec = 0; e_opc = 0;
    repeat (3) @(negedge clk);
    // R1 reset outputs
    chk("R1", "svc_req", 16'(svc), 0); chk("R1", "push_pc", 16'(push), 0);
    chk("R1", "inta", 16'(inta), 0);   chk("R1", "opcode_vld", 16'(ovld), 0);
    rst_n = 1;
    // R1 masked and disabled after reset
    r65 = 1; r55 = 1; gen = 0; bnd = 1; step("R1");
    ei = 1; bnd = 0; step("R1");
    ei = 0; bnd = 1; step("R1");        // all masked: nothing taken
    r65 = 0; r55 = 0; gen = 1; step("R1"); // enabled general request taken
    quiet(); gen = 0; dbus = 8'h5A; step("R9");
    step("R9");
    // R2 trap with enable clear
    mwr = 1; mdat = 3'b000; step("R6"); quiet();
    trap = 1; step("R10"); bnd = 1; step("R2"); step("R10"); bnd = 0; trap = 0; step("R2");
    // R3 restart vectors
    ei = 1; step("R5"); ei = 0; r55 = 1; bnd = 1; step("R3"); quiet(); r55 = 0;
    ei = 1; step("R5"); ei = 0; r65 = 1; bnd = 1; step("R3"); quiet(); r65 = 0;
    ei = 1; r75 = 1; step("R3"); ei = 0; bnd = 1; step("R3"); step("R10"); quiet(); r75 = 0;
    // R8 no boundary, no service
    ei = 1; step("R8"); ei = 0; r65 = 1; step("R8"); step("R8");
    // R4 priority with all sources active
    r55 = 1; gen = 1; r75 = 1; trap = 1; step("R4");
    bnd = 1; step("R4"); bnd = 0; ei = 1; step("R5");
    ei = 0; bnd = 1; step("R4"); bnd = 0; ei = 1; step("R4");
    ei = 0; bnd = 1; step("R4"); bnd = 0; ei = 1; step("R4");
    ei = 0; bnd = 1; step("R4"); quiet();
    r65 = 0; r55 = 0; gen = 0; r75 = 0; trap = 0; step("R4");
    // R5 accept beats enable strobe in the same cycle
    ei = 1; step("R5"); r55 = 1; bnd = 1; ei = 1; step("R5");
    ei = 0; step("R5"); quiet(); r55 = 0;
    // R6 masked 7.5 edge survives
    mwr = 1; mdat = 3'b100; ei = 1; r75 = 1; step("R6"); quiet();
    bnd = 1; step("R6"); step("R6"); bnd = 0; mwr = 1; mdat = 3'b000; step("R6");
    mwr = 0; bnd = 1; step("R6"); quiet(); r75 = 0;
    // R7 clear strobe removes pending 7.5
    ei = 1; r75 = 1; step("R7"); ei = 0; clr = 1; step("R7"); clr = 0; bnd = 1; step("R7");
    quiet(); r75 = 0;
    // R11 trap pending during acknowledge cycle
    ei = 1; gen = 1; step("R11"); ei = 0; bnd = 1; step("R11");
    gen = 0; trap = 1; dbus = 8'hC3; step("R11"); step("R11"); step("R11");
    quiet(); trap = 0; step("R11");
    // random run
    seed = 32'h1CE5;
    void'($urandom(seed));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) trap = ~trap;
      if ($urandom_range(5) == 0) r75 = ~r75;
      if ($urandom_range(4) == 0) r65 = ~r65;
      if ($urandom_range(4) == 0) r55 = ~r55;
      if ($urandom_range(4) == 0) gen = ~gen;
      bnd  = ($urandom_range(1) == 1);
      ei   = ($urandom_range(2) == 0);
      clr  = ($urandom_range(9) == 0);
      mwr  = ($urandom_range(11) == 0);
      mdat = 3'($urandom_range(7));
      dbus = 8'($urandom_range(255));
      step("R4");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule